// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This controller keeps the tag, valid and dirty state of a direct-mapped, write-back cache that allocates on both read and write misses. The processor side issues single-cycle request pulses. A lookup that matches a valid line completes on the next cycle and touches no memory. A write hit only marks the line modified.

On a miss, the controller fetches one whole line from memory. If the indexed line is valid and dirty, it first writes that line back to memory. A clean line that is displaced is simply dropped. The write-back and the fill run as one sequence that cannot be split, and the processor side stays busy until the sequence ends.

The line size is either 32 or 64 bytes. It is taken from a configuration pin while reset is held. It moves the boundary between the offset field and the index field of the address.

Top module: `dm_wb_cache_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cpu_busy`, `cpu_done` and `mem_req` are 0, and every line is invalid, so the first access to any index misses.
- R2: An accepted request whose index holds a valid line with a matching tag raises `cpu_done` with `cpu_hit`=1 exactly one cycle after acceptance, and raises no memory request.
- R3: The address splits into a low offset of 5 bits (32-byte line, config 0) or 6 bits (64-byte line, config 1), then log2(LINES) index bits, then the tag. The size is latched from `cfg_line64` only while reset is asserted, and every memory address is aligned to the latched line size.
- R4: A miss whose indexed line is invalid or clean issues exactly one fill (`mem_we`=0) at the request address with its offset bits cleared.
- R5: A miss whose indexed line is valid and dirty first issues a write (`mem_we`=1) at the victim's line base, rebuilt from the stored tag and the index. The fill of the new line follows it directly.
- R6: From acceptance of a miss until its `cpu_done`, `cpu_busy` stays 1, and any `cpu_valid` pulse in that window is ignored.
- R7: A write hit sets the line dirty without memory traffic. A read miss installs the line clean, and a write miss installs it dirty.
- R8: `mem_req` together with `mem_we` and `mem_addr` holds steady until `mem_ack` is seen.
- R9: `cpu_done` pulses for one cycle with `cpu_hit`=0 on the cycle after the fill's acknowledge. `mem_line64` reports the latched size of every one-line transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_line64 | input | 1 | Line size select, latched during reset (1 = 64 bytes) |
| cpu_valid | input | 1 | One-cycle request pulse, accepted when not busy |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request byte address |
| cpu_busy | output | 1 | Miss sequence in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed request hit, valid with `cpu_done` |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | Transfer is a write-back |
| mem_addr | output | ADDR_W | Line-aligned transfer address |
| mem_line64 | output | 1 | Transfer length, 1 = 64 bytes, 0 = 32 bytes |
| mem_ack | input | 1 | Transfer complete, one cycle |

## Verification
A hit completes one cycle after the edge that accepts it. A miss shows its first memory request one cycle after acceptance. Each acknowledge moves the sequence on at the next edge, and `cpu_done` follows one cycle after the fill's acknowledge.

The bench drives inputs and samples outputs on falling edges, so every check lands in the cycle the registers predict. It counts the cycles to completion to confirm the single-cycle hit. It also stalls acknowledges by zero to two cycles, and sends stray requests during those stalls.

// File: rtl/dm_wb_cache_ctrl.sv
module dm_wb_cache_ctrl #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_line64,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_line64,
  input  logic              mem_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - 5 - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL} st_t;

  st_t               st;
  logic              line64_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINES-1:0]  vld, dty;
  logic [TAG_W-1:0]  tags [LINES];

  logic [2:0]        off;
  logic [ADDR_W-1:0] in_sh, q_sh, line_base, victim_base;
  logic [IDX_W-1:0]  idx_in, idx_q;
  logic [TAG_W-1:0]  tag_in, tag_q;
  logic              hit_in;

  assign off         = line64_q ? 3'd6 : 3'd5;
  assign in_sh       = cpu_addr >> off;
  assign q_sh        = addr_q >> off;
  assign idx_in      = in_sh[IDX_W-1:0];
  assign idx_q       = q_sh[IDX_W-1:0];
  assign tag_in      = TAG_W'(in_sh >> IDX_W);
  assign tag_q       = TAG_W'(q_sh >> IDX_W);
  assign hit_in      = vld[idx_in] && (tags[idx_in] == tag_in);
  assign line_base   = q_sh << off;
  assign victim_base = ADDR_W'({tags[idx_q], idx_q}) << off;

  assign cpu_busy   = (st != S_IDLE);
  assign mem_req    = (st != S_IDLE);
  assign mem_we     = (st == S_WBACK);
  assign mem_addr   = (st == S_WBACK) ? victim_base : line_base;
  assign mem_line64 = line64_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line64_q <= cfg_line64;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vld      <= '0;
      dty      <= '0;
      cpu_done <= 1'b0;
      cpu_hit  <= 1'b0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      for (int i = 0; i < LINES; i++) tags[i] <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (st)
        S_IDLE: if (cpu_valid) begin
          addr_q <= cpu_addr;
          we_q   <= cpu_we;
          if (hit_in) begin
            cpu_done <= 1'b1;
            cpu_hit  <= 1'b1;
            if (cpu_we) dty[idx_in] <= 1'b1;
          end else begin
            cpu_hit <= 1'b0;
            st      <= (vld[idx_in] && dty[idx_in]) ? S_WBACK : S_FILL;
          end
        end
        S_WBACK: if (mem_ack) st <= S_FILL;
        S_FILL: if (mem_ack) begin
          vld[idx_q]  <= 1'b1;
          dty[idx_q]  <= we_q;
          tags[idx_q] <= tag_q;
          cpu_done    <= 1'b1;
          cpu_hit     <= 1'b0;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !cpu_busy && !cpu_done && !mem_req); // R1
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_busy && hit_in |=> cpu_done && cpu_hit && !mem_req); // R2
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & (mem_line64 ? ADDR_W'(63) : ADDR_W'(31))) == '0); // R3
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we); // R5
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_busy && !(mem_req && !mem_we && mem_ack) |=> cpu_busy); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> cpu_done && !cpu_hit && !cpu_busy); // R9
endmodule

// File: tb/dm_wb_cache_ctrl_tb_top.sv
module dm_wb_cache_ctrl_tb_top;
  localparam int AW = 16;
  localparam int NL = 8;

  logic clk = 1'b0, rst_n = 1'b0, cfg_line64 = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, mem_ack = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_busy, cpu_done, cpu_hit, mem_req, mem_we, mem_line64;
  logic [AW-1:0] mem_addr;

  dm_wb_cache_ctrl #(.ADDR_W(AW), .LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_line64(cfg_line64),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_line64(mem_line64), .mem_ack(mem_ack));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mv [NL];
  bit md [NL];
  int mt [NL];
  bit m64;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R6 watchdog: actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit cfg);
    rst_n = 0; cfg_line64 = cfg;
    repeat (3) @(negedge clk);
    chk(!cpu_busy && !cpu_done && !mem_req, "R1", {cpu_busy, cpu_done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    cfg_line64 = !cfg;
    chk(!cpu_busy && !cpu_done && !mem_req, "R1", {cpu_busy, cpu_done, mem_req}, 0);
    chk(mem_line64 == cfg, "R3", mem_line64, cfg);
    m64 = cfg;
    for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
  endtask

  task automatic access(logic [AW-1:0] addr, bit we, int lat);
    int off = m64 ? 6 : 5;
    int idx = (addr >> off) % NL;
    int tag = addr >> (off + 3);
    bit ehit = mv[idx] && mt[idx] == tag;
    bit ewb = !ehit && mv[idx] && md[idx];
    int wba = ((mt[idx] << 3) | idx) << off;
    int fla = (addr >> off) << off;
    int ntx = 0, n = 0, wt = 0;
    bit got = 0;
    logic [AW-1:0] pa = '0;
    cpu_valid = 1; cpu_addr = addr; cpu_we = we;
    @(negedge clk);
    cpu_valid = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      n++;
      mem_ack = 0; cpu_valid = 0;
      if (cpu_done) got = 1;
      else begin
        chk(cpu_busy, "R6", cpu_busy, 1);
        if (mem_req) begin
          if (wt > 0) chk(mem_addr == pa, "R8", mem_addr, pa);
          pa = mem_addr;
          if (wt < lat) begin
            wt++;
            cpu_valid = 1; cpu_addr = ~addr; cpu_we = 1;
          end else begin
            if (ntx == 0 && ewb) begin
              chk(mem_we == 1, "R5", mem_we, 1);
              chk(mem_addr == AW'(wba), "R5", mem_addr, AW'(wba));
            end else begin
              chk(mem_we == 0, "R4", mem_we, 0);
              chk(mem_addr == AW'(fla), "R4", mem_addr, AW'(fla));
            end
            chk((mem_addr & AW'((1 << off) - 1)) == 0, "R3", mem_addr, 0);
            chk(mem_line64 == m64, "R9", mem_line64, m64);
            ntx++; wt = 0; mem_ack = 1;
          end
        end
        @(negedge clk);
      end
    end
    mem_ack = 0; cpu_valid = 0;
    chk(got, "R6", got, 1);
    chk(cpu_hit == ehit, ehit ? "R2" : "R9", cpu_hit, ehit);
    if (ehit) chk(n == 1, "R2", n, 1);
    chk(ntx == (ehit ? 0 : (ewb ? 2 : 1)), "R7", ntx, ehit ? 0 : (ewb ? 2 : 1));
    @(negedge clk);
    chk(!cpu_done && !cpu_busy && !mem_req, "R9", {cpu_done, cpu_busy, mem_req}, 0);
    if (ehit) begin
      if (we) md[idx] = 1;
    end else begin
      mv[idx] = 1; mt[idx] = tag; md[idx] = we;
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int r = 0; r < 16; r++) begin
        for (int i = 0; i < NL; i++) begin
          int off = m64 ? 6 : 5;
          int t = ((r >> 1) + i) % 3;
          int o = (r * 7 + i * 3) % (1 << off);
          access(AW'((t << (off + 3)) | (i << off) | o), bit'((r + i) & 1), (r + i) % 3);
        end
      end
      access(16'hFFFF, 1, 1);
      access(16'hFFFF, 0, 0);
      access(16'h7FFF, 0, 2);
      access(16'hFFFF, 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule